// File: doc/BRIEF.md
# Coprocessor Enable and Output Gate

This block is the interface wrapper that sits at the front of one coprocessor. It lets that coprocessor share a set of return wires with several others. The core drives one enable line per coprocessor, and it raises at most one of them at a time. It also broadcasts every instruction to all attached units, together with a coprocessor number and a flag that marks core-only instructions. The wrapper decides whether its own execution pipeline should take each instruction. It also makes sure that everything it drives back to the core is zero whenever it is not the selected unit. The core can then OR the responses of all units together.

The wrapper tracks its enable line in three phases: off, waking and running. While off, every output back to the core is held at zero, instruction strobes are blocked, and a flush request is raised so that the pipeline drops its valid bits. On the first clock edge that sees the enable high, the handshake outputs report an empty pipeline for exactly one cycle: both hold flags high, and store-valid and store data low. After that cycle, the outputs follow the values the pipeline offers. Every output is a register, so each response appears one cycle after the clock edge that sampled its inputs.

Top module: `copro_port_gate`

## Requirements
- R1: While reset is high, every gated output and the accept strobe are 0 and the flush request is 1.
- R2: One cycle after a clock edge at which the enable line is 0, length-hold, accept-hold, store-valid and store data are all 0, whatever the pipeline presents.
- R3: The flush request is 1 in the cycle after an edge with enable 0, and 0 in the cycle after an edge with enable 1.
- R4: After the first edge with enable 1 that follows an edge with enable 0 (or reset), length-hold and accept-hold are 1 and store-valid and store data are 0 for one cycle, regardless of the pipeline values.
- R5: After an edge with enable 1 whose preceding edge also had enable 1, each gated output equals the pipeline value sampled at that edge.
- R6: The accept strobe is 1 in the cycle after an edge at which enable is 1 (and was 1 at the preceding edge), the instruction is valid, the core flag is 0 and the number equals the unit ID.
- R7: An instruction whose number differs from the unit ID never raises the accept strobe.
- R8: An instruction with the core flag set (core-only instruction) never raises the accept strobe, even if its number matches.
- R9: A matching instruction seen at an edge with enable 0, or at the first enabled edge after a disabled one, is ignored: the accept strobe stays 0.
- R10: The unit ID is a parameter in the range 0 to 11 carried on a 4-bit number field, so the numbers 12 to 15 never raise the accept strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Select line from the core for this unit |
| ins_valid_i | input | 1 | A broadcast instruction is present |
| ins_num_i | input | NUM_W | Coprocessor number carried by the instruction |
| ins_is_core_i | input | 1 | 1 marks a core-only instruction |
| pl_len_hold_i | input | 1 | Length-hold value from the pipeline |
| pl_acc_hold_i | input | 1 | Accept-hold value from the pipeline |
| pl_st_valid_i | input | 1 | Store-data-valid value from the pipeline |
| pl_st_data_i | input | DATA_W | Store data from the pipeline |
| len_hold_o | output | 1 | Gated length-hold toward the shared OR bus |
| acc_hold_o | output | 1 | Gated accept-hold toward the shared OR bus |
| st_valid_o | output | 1 | Gated store-data-valid toward the shared OR bus |
| st_data_o | output | DATA_W | Gated store data toward the shared OR bus |
| pl_accept_o | output | 1 | Strobe that hands the current instruction to the pipeline |
| pl_flush_o | output | 1 | Request for the pipeline to clear its valid bits |

## Verification
Instruction filtering and the enable transition can fall on the same clock edge. A matching, valid instruction may arrive exactly at the edge where enable rises, or where it falls, while the pipeline inputs show a busy state. The sweep produces these collisions by giving each stimulus a preamble cycle whose enable differs from that of the measured cycle, and by holding every pipeline input and the instruction fields at active values in the preamble. The result passes only if the forced empty-pipeline state (or all-zero state) wins over the pipeline values and the accept strobe stays low in both cases.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  // Life cycle of the unit as seen from its select line
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_WAKE = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;
endpackage

// File: rtl/cpg_phase.sv
module cpg_phase
  import cpg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en_i,
  output phase_t ph_nxt
);
  phase_t ph_q;

  always_comb begin
    if (!en_i)
      ph_nxt = PH_OFF;
    else if (ph_q == PH_OFF)
      ph_nxt = PH_WAKE;
    else
      ph_nxt = PH_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ph_q <= PH_OFF;
    else
      ph_q <= ph_nxt;
  end
endmodule

// File: rtl/cpg_filter.sv
module cpg_filter #(
  parameter int unsigned NUM_W = 4,
  parameter int unsigned ID    = 0
) (
  input  logic             valid_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic             is_core_i,
  output logic             hit_o
);
  localparam logic [NUM_W-1:0] MY_NUM = NUM_W'(ID);

  always_comb begin
    hit_o = valid_i && !is_core_i && (num_i == MY_NUM);
  end
endmodule

// File: rtl/cpg_gate.sv
module cpg_gate
  import cpg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            ph_nxt,
  input  logic              hit_i,
  input  logic              len_hold_i,
  input  logic              acc_hold_i,
  input  logic              st_valid_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              len_hold_o,
  output logic              acc_hold_o,
  output logic              st_valid_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              accept_o,
  output logic              flush_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      len_hold_o <= 1'b0;
      acc_hold_o <= 1'b0;
      st_valid_o <= 1'b0;
      st_data_o  <= '0;
      accept_o   <= 1'b0;
      flush_o    <= 1'b1;
    end else begin
      unique case (ph_nxt)
        PH_WAKE: begin
          len_hold_o <= 1'b1;
          acc_hold_o <= 1'b1;
          st_valid_o <= 1'b0;
          st_data_o  <= '0;
          accept_o   <= 1'b0;
          flush_o    <= 1'b0;
        end
        PH_RUN: begin
          len_hold_o <= len_hold_i;
          acc_hold_o <= acc_hold_i;
          st_valid_o <= st_valid_i;
          st_data_o  <= st_data_i;
          accept_o   <= hit_i;
          flush_o    <= 1'b0;
        end
        default: begin
          len_hold_o <= 1'b0;
          acc_hold_o <= 1'b0;
          st_valid_o <= 1'b0;
          st_data_o  <= '0;
          accept_o   <= 1'b0;
          flush_o    <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/copro_port_gate.sv
module copro_port_gate
  import cpg_pkg::*;
#(
  parameter int unsigned NUM_W     = 4,
  parameter int unsigned NUM_UNITS = 12,
  parameter int unsigned ID        = 0,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              ins_valid_i,
  input  logic [NUM_W-1:0]  ins_num_i,
  input  logic              ins_is_core_i,
  input  logic              pl_len_hold_i,
  input  logic              pl_acc_hold_i,
  input  logic              pl_st_valid_i,
  input  logic [DATA_W-1:0] pl_st_data_i,
  output logic              len_hold_o,
  output logic              acc_hold_o,
  output logic              st_valid_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              pl_accept_o,
  output logic              pl_flush_o
);
  phase_t ph_nxt;
  logic   hit;

  cpg_phase u_phase (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .ph_nxt (ph_nxt)
  );

  cpg_filter #(
    .NUM_W (NUM_W),
    .ID    (ID)
  ) u_filter (
    .valid_i   (ins_valid_i),
    .num_i     (ins_num_i),
    .is_core_i (ins_is_core_i),
    .hit_o     (hit)
  );

  cpg_gate #(
    .DATA_W (DATA_W)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .ph_nxt     (ph_nxt),
    .hit_i      (hit),
    .len_hold_i (pl_len_hold_i),
    .acc_hold_i (pl_acc_hold_i),
    .st_valid_i (pl_st_valid_i),
    .st_data_i  (pl_st_data_i),
    .len_hold_o (len_hold_o),
    .acc_hold_o (acc_hold_o),
    .st_valid_o (st_valid_o),
    .st_data_o  (st_data_o),
    .accept_o   (pl_accept_o),
    .flush_o    (pl_flush_o)
  );
endmodule

// File: rtl/cpg_checker.sv
module cpg_checker #(
  parameter int unsigned NUM_W     = 4,
  parameter int unsigned NUM_UNITS = 12,
  parameter int unsigned ID        = 0,
  parameter int unsigned DATA_W    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              ins_valid_i,
  input logic [NUM_W-1:0]  ins_num_i,
  input logic              ins_is_core_i,
  input logic              pl_len_hold_i,
  input logic              pl_acc_hold_i,
  input logic              pl_st_valid_i,
  input logic [DATA_W-1:0] pl_st_data_i,
  input logic              len_hold_o,
  input logic              acc_hold_o,
  input logic              st_valid_o,
  input logic [DATA_W-1:0] st_data_o,
  input logic              pl_accept_o,
  input logic              pl_flush_o
);
  logic seen_en;
  logic take;

  always_ff @(posedge clk) begin
    if (rst) seen_en <= 1'b0;
    else     seen_en <= en_i;
  end

  assign take = ins_valid_i && !ins_is_core_i && (ins_num_i == NUM_W'(ID));

  // R10: the unit ID must name one of the attached units
  initial begin
    p_id_range_r10: assert (ID < NUM_UNITS && NUM_UNITS <= (1 << NUM_W));
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pl_flush_o && !pl_accept_o && !len_hold_o && !acc_hold_o && !st_valid_o && st_data_o == '0));

  p_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!len_hold_o && !acc_hold_o && !st_valid_o && st_data_o == '0));

  p_flush_on_r3: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> pl_flush_o);

  p_flush_off_r3: assert property (@(posedge clk) disable iff (rst)
    en_i |=> !pl_flush_o);

  p_wake_state_r4: assert property (@(posedge clk) disable iff (rst)
    (en_i && !seen_en) |=> (len_hold_o && acc_hold_o && !st_valid_o && st_data_o == '0));

  p_follow_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && seen_en) |=> (len_hold_o == $past(pl_len_hold_i) && acc_hold_o == $past(pl_acc_hold_i)
                           && st_valid_o == $past(pl_st_valid_i) && st_data_o == $past(pl_st_data_i)));

  p_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (en_i && seen_en && take) |=> pl_accept_o);

  p_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (ins_num_i != NUM_W'(ID)) |=> !pl_accept_o);

  p_core_reject_r8: assert property (@(posedge clk) disable iff (rst)
    ins_is_core_i |=> !pl_accept_o);

  p_idle_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_i || !seen_en) |=> !pl_accept_o);
endmodule

bind copro_port_gate cpg_checker #(
  .NUM_W     (NUM_W),
  .NUM_UNITS (NUM_UNITS),
  .ID        (ID),
  .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/sim_copro_port_gate.sv
`timescale 1ns/1ps
module sim_copro_port_gate;
  localparam int unsigned NUM_W  = 4;
  localparam int unsigned NUNITS = 12;
  localparam int unsigned MY_ID  = 5;
  localparam int unsigned DW     = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          en_i, ins_valid_i, ins_is_core_i;
  logic [NUM_W-1:0] ins_num_i;
  logic          pl_len_hold_i, pl_acc_hold_i, pl_st_valid_i;
  logic [DW-1:0] pl_st_data_i;
  logic          len_hold_o, acc_hold_o, st_valid_o, pl_accept_o, pl_flush_o;
  logic [DW-1:0] st_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit m_en_prev = 1'b0;

  always #2.5 clk = ~clk;

  copro_port_gate #(
    .NUM_W(NUM_W), .NUM_UNITS(NUNITS), .ID(MY_ID), .DATA_W(DW)
  ) u0 (
    .clk(clk), .rst(rst), .en_i(en_i), .ins_valid_i(ins_valid_i),
    .ins_num_i(ins_num_i), .ins_is_core_i(ins_is_core_i),
    .pl_len_hold_i(pl_len_hold_i), .pl_acc_hold_i(pl_acc_hold_i),
    .pl_st_valid_i(pl_st_valid_i), .pl_st_data_i(pl_st_data_i),
    .len_hold_o(len_hold_o), .acc_hold_o(acc_hold_o), .st_valid_o(st_valid_o),
    .st_data_o(st_data_o), .pl_accept_o(pl_accept_o), .pl_flush_o(pl_flush_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge
  task automatic step(input bit r, input bit en, input bit vld, input logic [3:0] num,
                      input bit core, input bit lh, input bit ah, input bit sv,
                      input logic [DW-1:0] dat);
    logic [DW+2:0] exp_out;
    bit exp_flush, exp_acc;
    string t_out, t_acc;
    rst = r; en_i = en; ins_valid_i = vld; ins_num_i = num; ins_is_core_i = core;
    pl_len_hold_i = lh; pl_acc_hold_i = ah; pl_st_valid_i = sv; pl_st_data_i = dat;
    if (r) begin
      exp_out = '0; exp_flush = 1'b1; exp_acc = 1'b0; t_out = "R1"; t_acc = "R1";
    end else if (!en) begin
      exp_out = '0; exp_flush = 1'b1; exp_acc = 1'b0; t_out = "R2"; t_acc = "R9";
    end else if (!m_en_prev) begin
      exp_out = {1'b1, 1'b1, 1'b0, {DW{1'b0}}}; exp_flush = 1'b0; exp_acc = 1'b0;
      t_out = "R4"; t_acc = "R9";
    end else begin
      exp_out = {lh, ah, sv, dat}; exp_flush = 1'b0;
      exp_acc = vld && !core && (num == 4'(MY_ID));
      t_out = "R5";
      if (!vld)                t_acc = "R6";
      else if (core)           t_acc = "R8";
      else if (num >= NUNITS)  t_acc = "R10";
      else if (num != MY_ID)   t_acc = "R7";
      else                     t_acc = "R6";
    end
    m_en_prev = r ? 1'b0 : en;
    @(posedge clk);
    @(negedge clk);
    check(t_out, 32'({len_hold_o, acc_hold_o, st_valid_o, st_data_o}), 32'(exp_out));
    check(r ? "R1" : "R3", 32'(pl_flush_o), 32'(exp_flush));
    check(t_acc, 32'(pl_accept_o), 32'(exp_acc));
  endtask

  initial begin
    #(5.0 * 60000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en_i = 1'b0; ins_valid_i = 1'b0; ins_num_i = '0; ins_is_core_i = 1'b0;
    pl_len_hold_i = 1'b0; pl_acc_hold_i = 1'b0; pl_st_valid_i = 1'b0; pl_st_data_i = '0;
    @(negedge clk);
    // R1: reset with every input active
    step(1'b1, 1'b1, 1'b1, 4'(MY_ID), 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF);
    step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

    // Sweep: a preamble cycle with busy pipeline and a matching instruction,
    // then a measured cycle, for all four enable pairs and all input combinations
    for (int h = 0; h < 4; h++) begin
      for (int v = 0; v < 512; v++) begin
        step(1'b0, h[1], 1'b1, 4'(MY_ID), 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF);
        step(1'b0, h[0], v[0], v[5:2], v[1], v[6], v[7], v[8], 8'(v * 37 + h));
      end
    end

    // R6: back-to-back accepts in a long enabled run, then disable while matching (R9)
    step(1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 8; k++)
      step(1'b0, 1'b1, 1'b1, 4'(MY_ID), 1'b0, k[0], k[1], k[2], 8'(k + 8'hA0));
    step(1'b0, 1'b0, 1'b1, 4'(MY_ID), 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A);
    step(1'b0, 1'b1, 1'b1, 4'(MY_ID), 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C);
    step(1'b0, 1'b1, 1'b1, 4'(MY_ID), 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C);

    // R1: reset in the middle of an enabled run, then wake again (R4)
    step(1'b1, 1'b1, 1'b1, 4'(MY_ID), 1'b0, 1'b1, 1'b1, 1'b1, 8'h77);
    step(1'b0, 1'b1, 1'b1, 4'(MY_ID), 1'b0, 1'b0, 1'b0, 1'b1, 8'h77);
    step(1'b0, 1'b1, 1'b1, 4'(MY_ID), 1'b0, 1'b0, 1'b0, 1'b1, 8'h77);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule